// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Redirection Controller

This block is the register front end of an interrupt redirection controller with a parameterised number of input pins (24 by default). Software reaches all internal state through two word-aligned bus offsets. A select register at offset 0x00 holds an 8-bit index. A data window at offset 0x10 reads or writes the register that the index names. Behind the window sit a read-only version word, a 4-bit controller ID, and a redirection table. The table has one 64-bit entry per pin, and each entry is reached as two 32-bit halves.

The block owns the table storage and its reset values. Two bits of each entry belong to the hardware: delivery status and remote-IRR. A window write never changes them; they change only through a dedicated status-update port. When a write leaves an entry in edge mode, the block clears its remote-IRR bit. The block also emits two one-cycle notifications: one when a write flips an entry's mask bit, and one when a write leaves a level-triggered entry in a state where it should be serviced. Delivery and end-of-interrupt handling are done by neighbouring logic.

Top module: `irq_regwin`

## Requirements
- R1: A bus write to offset 0x00 stores bits 7:0 of the write data as the select index. A bus read of offset 0x00 returns that index zero-extended to 32 bits.
- R2: Every bus read returns its data one clock later, with `rd_valid_o` high for exactly that cycle. `rd_valid_o` stays low after writes and idle cycles.
- R3: A window read with index 0x01 returns NPINS-1 in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits zero. Window writes at index 0x01 change nothing.
- R4: Index 0x00 holds a 4-bit ID in bits 27:24 and is readable and writable. Index 0x02 reads the same ID, and writes to index 0x02 are ignored.
- R5: An index of 0x10 or more addresses table entry (index-0x10)>>1. An odd index reaches bits 63:32 and an even index reaches bits 31:0. Entry fields: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, remote-IRR 14, trigger 15 (1 = level), mask 16, destination 63:56.
- R6: A window read at an index below 0x10 other than 0x00 to 0x02, or at an index naming an entry at or beyond NPINS, returns 0xFFFFFFFF. A window write at any such index is dropped.
- R7: A window write to an entry leaves its delivery-status bit (12) and its remote-IRR bit (14) as they were, except as stated in R8.
- R8: If an entry's trigger bit (15) is 0 after a window write, that entry's remote-IRR bit is 0.
- R9: After reset, every entry reads mask bit 16 set and all other bits 0. The select index, the ID and the pending-request state read 0.
- R10: A window write that changes an entry's mask bit sets `mchg_valid_o` for one cycle in the next clock, with the pin number and the new mask value. A write that leaves the mask unchanged produces no pulse.
- R11: A window write after which the entry is level-triggered, unmasked and has remote-IRR clear, while that pin's pending bit is set, sets `svc_valid_o` for one cycle in the next clock with the pin number. The pending bit is `line_i` registered once.
- R12: A bus read at any offset other than 0x00 and 0x10 returns 0, and a bus write there changes nothing.
- R13: A status-port write loads bits 12 and 14 of the named entry. It is dropped if a window write hits the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset within the block |
| wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| line_i | input | NPINS | Interrupt line levels |
| stat_we_i | input | 1 | Status-port write strobe |
| stat_pin_i | input | PIN_W | Status-port entry number |
| stat_deliv_i | input | 1 | New delivery-status value |
| stat_remote_i | input | 1 | New remote-IRR value |
| mchg_valid_o | output | 1 | Mask-change pulse |
| mchg_pin_o | output | PIN_W | Pin whose mask changed |
| mchg_mask_o | output | 1 | New mask value |
| svc_valid_o | output | 1 | Service-request pulse |
| svc_pin_o | output | PIN_W | Pin to service |

## Verification
The bench uses the default parameters: 24 pins and a version code of 0x11. With these values the table ends at index 0x3F, so random select values up to 0x43 reach the first out-of-range index, 0x40, as well as the last valid high half. All 8-bit indices, including the gap 0x03 to 0x0F, stay reachable because the index decode is as wide as the select register. With 24 pins, random traffic can hit every entry's mask and service paths within a few hundred operations.

// File: rtl/irq_regwin_pkg.sv
`timescale 1ns/1ps
package irq_regwin_pkg;
  localparam int ENTRY_W    = 64;
  localparam int B_DELIV    = 12;
  localparam int B_REMOTE   = 14;
  localparam int B_LEVEL    = 15;
  localparam int B_MASK     = 16;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;
  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/irq_regwin_decode.sv
`timescale 1ns/1ps
module irq_regwin_decode
  import irq_regwin_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic [7:0] sel_i,
  output logic       is_ver_o,
  output logic       is_idrd_o,
  output logic       is_idwr_o,
  output logic       hit_o,
  output logic       hi_o,
  output logic [6:0] idx_o
);
  logic [7:0] off;
  logic       is_tbl;

  assign off       = sel_i - IDX_TBL;
  assign is_tbl    = (sel_i >= IDX_TBL);
  assign idx_o     = off[7:1];
  assign hi_o      = off[0];
  assign hit_o     = is_tbl && (int'(idx_o) < NPINS);
  assign is_ver_o  = (sel_i == IDX_VER);
  assign is_idwr_o = (sel_i == IDX_ID);
  assign is_idrd_o = (sel_i == IDX_ID) || (sel_i == IDX_ARB);
endmodule

// File: rtl/irq_regwin_entry.sv
`timescale 1ns/1ps
module irq_regwin_entry
  import irq_regwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic               hi_i,
  input  logic [31:0]        wdata_i,
  input  logic               st_we_i,
  input  logic               st_deliv_i,
  input  logic               st_remote_i,
  output logic [ENTRY_W-1:0] q_o,
  output logic               nmask_o,
  output logic               nlevel_o,
  output logic               nremote_o
);
  logic [ENTRY_W-1:0] merged;

  always_comb begin
    merged = hi_i ? {wdata_i, q_o[31:0]} : {q_o[63:32], wdata_i};
    merged[B_DELIV]  = q_o[B_DELIV];
    merged[B_REMOTE] = merged[B_LEVEL] ? q_o[B_REMOTE] : 1'b0;
  end

  assign nmask_o   = merged[B_MASK];
  assign nlevel_o  = merged[B_LEVEL];
  assign nremote_o = merged[B_REMOTE];

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= ENTRY_RST;
    end else if (we_i) begin
      q_o <= merged;
    end else if (st_we_i) begin
      q_o[B_DELIV]  <= st_deliv_i;
      q_o[B_REMOTE] <= st_remote_i;
    end
  end

  assert_keep_status_R7: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (q_o[B_DELIV] == $past(q_o[B_DELIV])));

  assert_edge_clear_R8: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (q_o[B_LEVEL] || !q_o[B_REMOTE]));
endmodule

// File: rtl/irq_regwin.sv
`timescale 1ns/1ps
module irq_regwin
  import irq_regwin_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int        PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_i,
  input  logic             wr_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic             rd_valid_o,
  output logic [31:0]      rd_data_o,
  input  logic [NPINS-1:0] line_i,
  input  logic             stat_we_i,
  input  logic [PIN_W-1:0] stat_pin_i,
  input  logic             stat_deliv_i,
  input  logic             stat_remote_i,
  output logic             mchg_valid_o,
  output logic [PIN_W-1:0] mchg_pin_o,
  output logic             mchg_mask_o,
  output logic             svc_valid_o,
  output logic [PIN_W-1:0] svc_pin_o
);
  localparam logic [7:0] TOP_PIN = 8'(NPINS - 1);

  logic [7:0]         sel_q;
  logic [3:0]         id_q;
  logic [NPINS-1:0]   pend_q;
  logic               is_ver, is_idrd, is_idwr, hit, hi;
  logic [6:0]         idx;
  logic [PIN_W-1:0]   pin;
  logic               win_wr, sel_wr;
  logic [ENTRY_W-1:0] q_arr     [NPINS];
  logic [NPINS-1:0]   nmask_v, nlevel_v, nremote_v, mask_v;
  logic [31:0]        rd_mux;

  assign win_wr = acc_i && wr_i && (addr_i == OFF_WIN);
  assign sel_wr = acc_i && wr_i && (addr_i == OFF_SEL);
  assign pin    = idx[PIN_W-1:0];

  irq_regwin_decode #(.NPINS(NPINS)) u_dec (
    .sel_i(sel_q), .is_ver_o(is_ver), .is_idrd_o(is_idrd), .is_idwr_o(is_idwr),
    .hit_o(hit), .hi_o(hi), .idx_o(idx)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    logic we_e, st_e;
    assign we_e = win_wr && hit && (pin == PIN_W'(i));
    assign st_e = stat_we_i && (stat_pin_i == PIN_W'(i)) && !we_e;
    irq_regwin_entry u_ent (
      .clk(clk), .rst(rst), .we_i(we_e), .hi_i(hi), .wdata_i(wdata_i),
      .st_we_i(st_e), .st_deliv_i(stat_deliv_i), .st_remote_i(stat_remote_i),
      .q_o(q_arr[i]), .nmask_o(nmask_v[i]), .nlevel_o(nlevel_v[i]),
      .nremote_o(nremote_v[i])
    );
    assign mask_v[i] = q_arr[i][B_MASK];
  end

  always_comb begin
    rd_mux = 32'h0;
    if (addr_i == OFF_SEL) begin
      rd_mux = {24'h0, sel_q};
    end else if (addr_i == OFF_WIN) begin
      if (is_ver)       rd_mux = {8'h0, TOP_PIN, 8'h0, VERSION};
      else if (is_idrd) rd_mux = {4'h0, id_q, 24'h0};
      else if (hit)     rd_mux = hi ? q_arr[pin][63:32] : q_arr[pin][31:0];
      else              rd_mux = 32'hFFFF_FFFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q        <= '0;
      id_q         <= '0;
      pend_q       <= '0;
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      mchg_valid_o <= 1'b0;
      mchg_pin_o   <= '0;
      mchg_mask_o  <= 1'b0;
      svc_valid_o  <= 1'b0;
      svc_pin_o    <= '0;
    end else begin
      pend_q     <= line_i;
      rd_valid_o <= acc_i && !wr_i;
      if (acc_i && !wr_i) rd_data_o <= rd_mux;
      if (sel_wr) sel_q <= wdata_i[7:0];
      if (win_wr && is_idwr) id_q <= wdata_i[27:24];
      mchg_valid_o <= win_wr && hit && (nmask_v[pin] != mask_v[pin]);
      mchg_pin_o   <= pin;
      mchg_mask_o  <= nmask_v[pin];
      svc_valid_o  <= win_wr && hit && nlevel_v[pin] && !nmask_v[pin]
                      && !nremote_v[pin] && pend_q[pin];
      svc_pin_o    <= pin;
    end
  end

  assert_sel_store_R1: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (sel_q == $past(wdata_i[7:0])));

  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_i && !wr_i) |=> rd_valid_o);

  assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(acc_i && !wr_i) |=> !rd_valid_o);

  assert_reset_mask_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_v));

  assert_mchg_cause_R10: assert property (@(posedge clk) disable iff (rst)
    mchg_valid_o |-> $past(win_wr));

  assert_svc_cause_R11: assert property (@(posedge clk) disable iff (rst)
    svc_valid_o |-> $past(win_wr));
endmodule

// File: tb/irq_regwin_test.sv
`timescale 1ns/1ps
module irq_regwin_test;
  localparam int N = 24;
  localparam int PW = $clog2(N);
  localparam logic [7:0] VER = 8'h11;

  logic clk = 0, rst = 1;
  logic acc = 0, wr = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [N-1:0] line = '0;
  logic st_we = 0, st_d = 0, st_r = 0;
  logic [PW-1:0] st_pin = '0;
  logic mchg_valid, mchg_mask, svc_valid;
  logic [PW-1:0] mchg_pin, svc_pin;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] mt [N];
  logic [7:0]  msel;
  logic [3:0]  mid;
  logic [N-1:0] mpend;

  always #10 clk = ~clk;

  irq_regwin #(.NPINS(N), .VERSION(VER)) uut (
    .clk(clk), .rst(rst), .acc_i(acc), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .line_i(line),
    .stat_we_i(st_we), .stat_pin_i(st_pin), .stat_deliv_i(st_d), .stat_remote_i(st_r),
    .mchg_valid_o(mchg_valid), .mchg_pin_o(mchg_pin), .mchg_mask_o(mchg_mask),
    .svc_valid_o(svc_valid), .svc_pin_o(svc_pin)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] merge(input logic [63:0] old, input bit hi,
                                        input logic [31:0] d);
    logic [63:0] n;
    n = hi ? {d, old[31:0]} : {old[63:32], d};
    n[12] = old[12];
    n[14] = n[15] ? old[14] : 1'b0;
    return n;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int idx;
    if (a == 8'h00) return {24'h0, msel};
    if (a != 8'h10) return 32'h0;
    if (msel == 8'h01) return {8'h0, 8'(N - 1), 8'h0, VER};
    if (msel == 8'h00 || msel == 8'h02) return {4'h0, mid, 24'h0};
    if (msel < 8'h10) return 32'hFFFF_FFFF;
    idx = (int'(msel) - 16) >> 1;
    if (idx >= N) return 32'hFFFF_FFFF;
    return msel[0] ? mt[idx][63:32] : mt[idx][31:0];
  endfunction

  task automatic bus(input bit w, input logic [7:0] a, input logic [31:0] d);
    acc = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    acc = 0; wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    e = model_read(a);
    bus(0, a, 32'h0);
    chk({tag, " R2 rd_valid"}, 64'(rd_valid), 64'd1);
    chk(tag, 64'(rd_data), 64'(e));
  endtask

  task automatic wrt(input logic [7:0] a, input logic [31:0] d, input string tag);
    bit em = 0, es = 0;
    int idx = 0;
    logic [63:0] nv = '0;
    if (a == 8'h10 && msel >= 8'h10) begin
      idx = (int'(msel) - 16) >> 1;
      if (idx < N) begin
        nv = merge(mt[idx], msel[0], d);
        em = (nv[16] != mt[idx][16]);
        es = nv[15] && !nv[16] && !nv[14] && mpend[idx];
      end
    end
    bus(1, a, d);
    chk({tag, " R2 no rd_valid"}, 64'(rd_valid), 64'd0);
    chk({tag, " R10 mchg_valid"}, 64'(mchg_valid), 64'(em));
    if (em) begin
      chk({tag, " R10 mchg_pin"}, 64'(mchg_pin), 64'(idx));
      chk({tag, " R10 mchg_mask"}, 64'(mchg_mask), 64'(nv[16]));
    end
    chk({tag, " R11 svc_valid"}, 64'(svc_valid), 64'(es));
    if (es) chk({tag, " R11 svc_pin"}, 64'(svc_pin), 64'(idx));
    if (a == 8'h00) msel = d[7:0];
    else if (a == 8'h10) begin
      if (msel == 8'h00) mid = d[27:24];
      else if (msel >= 8'h10 && idx < N) mt[idx] = nv;
    end
  endtask

  task automatic stat(input int p, input bit d, input bit r);
    st_we = 1; st_pin = PW'(p); st_d = d; st_r = r;
    @(negedge clk);
    st_we = 0;
    mt[p][12] = d; mt[p][14] = r;
  endtask

  task automatic set_line(input logic [N-1:0] v);
    line = v;
    @(negedge clk);
    mpend = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) mt[i] = 64'h0000_0000_0001_0000;
    msel = 0; mid = 0; mpend = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R9 reset state
    rd(8'h00, "R9 select after reset");
    rd(8'h10, "R9 ID after reset");
    for (int i = 0; i < N; i++) begin
      wrt(8'h00, 32'(16 + 2 * i), "R9 sel");
      rd(8'h10, "R9 entry low after reset");
      wrt(8'h00, 32'(17 + 2 * i), "R9 sel");
      rd(8'h10, "R9 entry high after reset");
    end

    // R1 low byte only
    wrt(8'h00, 32'h1234_5633, "R1 sel write");
    rd(8'h00, "R1 select readback");

    // R3 version, write ignored
    wrt(8'h00, 32'h01, "R3 sel");
    rd(8'h10, "R3 version");
    wrt(8'h10, 32'hFFFF_FFFF, "R3 write ignored");
    rd(8'h10, "R3 version after write");

    // R4 ID and its read-only alias
    wrt(8'h00, 32'h00, "R4 sel");
    wrt(8'h10, 32'hA5FF_FFFF, "R4 id write");
    rd(8'h10, "R4 id readback");
    wrt(8'h00, 32'h02, "R4 sel alias");
    rd(8'h10, "R4 alias read");
    wrt(8'h10, 32'h0F00_0000, "R4 alias write");
    wrt(8'h00, 32'h00, "R4 sel");
    rd(8'h10, "R4 id unchanged by alias write");

    // R12 unmapped offsets
    wrt(8'h20, 32'h0000_0077, "R12 write other offset");
    rd(8'h20, "R12 read other offset");
    rd(8'h00, "R12 select untouched");

    // R5 mapping, R10 mask change
    wrt(8'h00, 32'h16, "R5 sel entry3 low");
    wrt(8'h10, 32'h0000_8031, "R5 R10 unmask entry3");
    rd(8'h10, "R5 entry3 low");
    wrt(8'h00, 32'h17, "R5 sel entry3 high");
    wrt(8'h10, 32'hAB00_0000, "R5 entry3 high write");
    rd(8'h10, "R5 entry3 high");
    wrt(8'h00, 32'h16, "R5 sel");
    rd(8'h10, "R5 low untouched by high write");
    wrt(8'h10, 32'h0000_8032, "R10 same mask no pulse");

    // R6 out of range
    wrt(8'h00, 32'h40, "R6 sel beyond table");
    rd(8'h10, "R6 read beyond table");
    wrt(8'h10, 32'h0, "R6 write beyond table");
    wrt(8'h00, 32'h05, "R6 sel gap");
    rd(8'h10, "R6 read gap index");
    wrt(8'h10, 32'h0, "R6 write gap");
    wrt(8'h00, 32'h00, "R6 sel id");
    rd(8'h10, "R6 gap write left id");

    // R7, R13, R8
    stat(3, 1, 1);
    wrt(8'h00, 32'h16, "R7 sel");
    rd(8'h10, "R13 status loaded");
    wrt(8'h10, 32'h0000_8040, "R7 level write keeps status");
    rd(8'h10, "R7 status kept");
    wrt(8'h10, 32'h0000_5041, "R8 edge write");
    rd(8'h10, "R8 remote cleared, deliv kept");

    // R13 collision: window write wins, status dropped
    acc = 1; wr = 1; addr = 8'h10; wdata = 32'h0000_8050;
    st_we = 1; st_pin = PW'(3); st_d = 0; st_r = 1;
    @(negedge clk);
    acc = 0; wr = 0; st_we = 0;
    mt[3] = merge(mt[3], 1'b0, 32'h0000_8050);
    rd(8'h10, "R13 collision status dropped");

    // R11 service request
    set_line(N'(1) << 5);
    wrt(8'h00, 32'h1A, "R11 sel entry5");
    wrt(8'h10, 32'h0000_8060, "R11 level unmasked pending");
    stat(5, 0, 1);
    wrt(8'h10, 32'h0000_8061, "R11 remote set blocks");
    set_line('0);
    stat(5, 0, 0);
    wrt(8'h10, 32'h0000_8062, "R11 no pending no svc");

    // random traffic
    for (int k = 0; k < 600; k++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0: begin
          if ($urandom % 4 != 0) wrt(8'h00, 32'(16 + $urandom % 52), "R5 rand sel");
          else wrt(8'h00, $urandom, "R1 rand sel");
        end
        1, 2: begin
          logic [31:0] d;
          d = $urandom;
          if ($urandom % 2 == 0) d[16] = 1'b0;
          wrt(8'h10, d, "R7 rand window write");
        end
        3: rd(8'h10, "R5 rand window read");
        4: stat(int'($urandom % N), 1'($urandom), 1'($urandom));
        5: set_line(N'($urandom));
        default: rd(8'h00, "R1 rand select read");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule